// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is a serial peripheral interface master. It moves one burst of words per start command from a 16-entry transmit queue onto the serial line, and it places each word received during that burst into a 16-entry receive queue. Software writes the control word: enable, master mode, clock idle level, sampling phase, select polarity, a 2-bit select index, the word length and the burst length. Software then fills the transmit queue and sets the start bit. When the burst finishes, a sticky completion flag is set, and it can raise an interrupt.

The serial clock rate is not generated here. A one-cycle `sck_tick` pulse marks each half period of the serial clock, and each half period lasts from one tick to the next. The select line is asserted only while a burst runs and is released after its last word. It therefore marks valid data rather than framing a multi-burst transaction.

The sequencer has six states. IDLE waits for an accepted start. LOAD takes the next transmit word, or zero if the queue is empty. LEAD waits for a tick and makes the leading clock edge. TRAIL waits for a tick and makes the trailing clock edge. It returns to LEAD while bits remain in the word, and moves to STORE after the last bit. STORE pushes the received word and returns to LOAD while words remain. Otherwise it moves to FINISH, which releases the select line, reports completion and returns to IDLE.

Top module: `spi_burst_engine`

## Requirements
- R1: The register word index selects the register: 0 is receive data (a read pops), 1 is transmit data (a write pushes), 2 is control, 3 is interrupt enable, 4 is status and 5 is test. The control bits are: bit 0 enable, bit 1 master, bit 2 start, bit 4 clock idle level, bit 5 phase, bit 7 select active level, [13:12] select index, [24:19] word length minus one, [31:25] burst length minus one. The control register reads back what was written.
- R2: A start bit set while enable and master are both 1 and no burst is running starts a burst of exactly (burst field + 1) words, and the start bit reads 0 once the burst has begun. While enable is 0, the start bit stays 1 and no select line asserts.
- R3: While idle, every select output sits at the inverse of control bit 7. During a burst, only the indexed output is at the active level, and it is released exactly once per burst, after the last word.
- R4: Each queue holds 16 words. The test register reports the transmit count in bits [4:0] and the receive count in bits [9:5]. A write to a full transmit queue is dropped.
- R5: The status bits are: 0 transmit empty, 1 transmit at least half full, 2 transmit full, 3 receive not empty, 4 receive at least half full, 5 receive full, 6 receive overflow and 7 burst complete. Bit 7 sets at the end of every burst and is cleared by writing 1 to it. The `irq` output is the OR of the status bits that have their bit set in the interrupt-enable register.
- R6: Each word is shifted most significant bit first. Only the low (length) bits of a queue entry are used. Received words arrive right-aligned, with the upper bits zero. Lengths of 8, 16, 24 and 32 bits are supported.
- R7: `sclk` idles at the clock idle level. With phase 0, data is valid before the leading edge and is sampled on the leading edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R8: Test register bit 16, when set, feeds the outgoing data bit back into the receive shifter in place of `miso`.
- R9: Writing test register bit 31 as 1 empties both queues and sets both counts to 0.
- R10: If the transmit queue is empty when a word is due, that word is sent as all zeros and the burst still completes.
- R11: A word that completes while the receive queue is full is discarded, and status bit 6 sets. It stays set until 1 is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_tick | input | 1 | Half-period pulse of the serial clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at index 0) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Select outputs, level set by control bit 7 |

## Verification
The bench sweeps all four clock modes across the four word lengths, with burst sizes that vary and with the select index and polarity rotating. A slave model samples the data line on the edge the mode calls for and drives its own arithmetic word stream back. A design that samples on the wrong edge, or shifts before the first leading edge in phase 1, returns words that are off by one bit. A design that releases the select line between words shows more than one release per burst. Dedicated cases cover each of the following:
- A burst that runs the transmit queue dry, which must send zeros rather than hang.
- A second burst into a full receive queue, which must keep the older words and set the overflow flag.
- A start issued while the block is disabled, which must stay pending.
- The queue flush.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LOAD,
        SH_LEAD,
        SH_TRAIL,
        SH_STORE,
        SH_FINISH
    } shift_state_e;

    // register word indices
    localparam logic [2:0] RIDX_RXD  = 3'd0;
    localparam logic [2:0] RIDX_TXD  = 3'd1;
    localparam logic [2:0] RIDX_CTRL = 3'd2;
    localparam logic [2:0] RIDX_IEN  = 3'd3;
    localparam logic [2:0] RIDX_STAT = 3'd4;
    localparam logic [2:0] RIDX_TEST = 3'd5;

    // control bit positions
    localparam int CB_EN     = 0;
    localparam int CB_MASTER = 1;
    localparam int CB_START  = 2;
    localparam int CB_CPOL   = 4;
    localparam int CB_CPHA   = 5;
    localparam int CB_CSPOL  = 7;
    localparam int CB_IDX_LO = 12;
    localparam int CB_LEN_LO = 19;
    localparam int CB_BST_LO = 25;

    // test register bit positions
    localparam int TB_LOOP  = 16;
    localparam int TB_FLUSH = 31;

    // status bit positions
    localparam int SB_OVF  = 6;
    localparam int SB_DONE = 7;

endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
    import spi_burst_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BURST_W = 7,
    parameter int NUM_CS  = 4,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int IDX_W  = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               cspol,
    input  logic [IDX_W-1:0]   cs_idx,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic [BURST_W-1:0] burst_m1,
    input  logic               loopback,
    input  logic               tx_empty,
    input  logic [DATA_W-1:0]  tx_word,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [DATA_W-1:0]  rx_word,
    output logic               busy,
    output logic               done,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_CS-1:0]  cs_out
);

    shift_state_e state, nxt;

    logic               cpol_l, cpha_l, cspol_l;
    logic [IDX_W-1:0]   idx_l;
    logic [LEN_W-1:0]   len_l;
    logic [LEN_W-1:0]   bit_cnt;
    logic [BURST_W-1:0] words_left;
    logic [DATA_W-1:0]  tx_sh;
    logic [DATA_W-1:0]  rx_sh;
    logic               phase_hi;
    logic               first;
    logic               in_bit;
    logic               cs_on;
    logic               cs_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE:   if (start) nxt = SH_LOAD;
            SH_LOAD:   nxt = SH_LEAD;
            SH_LEAD:   if (tick) nxt = SH_TRAIL;
            SH_TRAIL:  if (tick) nxt = (bit_cnt == '0) ? SH_STORE : SH_LEAD;
            SH_STORE:  nxt = (words_left == '0) ? SH_FINISH : SH_LOAD;
            SH_FINISH: nxt = SH_IDLE;
            default:   nxt = SH_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_l     <= 1'b0;
            cpha_l     <= 1'b0;
            cspol_l    <= 1'b0;
            idx_l      <= '0;
            len_l      <= '0;
            bit_cnt    <= '0;
            words_left <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            phase_hi   <= 1'b0;
            first      <= 1'b0;
        end else begin
            case (state)
                SH_IDLE: begin
                    cpol_l     <= cpol;
                    cpha_l     <= cpha;
                    cspol_l    <= cspol;
                    idx_l      <= cs_idx;
                    len_l      <= len_m1;
                    words_left <= burst_m1;
                    phase_hi   <= 1'b0;
                end
                SH_LOAD: begin
                    tx_sh   <= tx_empty ? '0 : tx_word;
                    rx_sh   <= '0;
                    bit_cnt <= len_l;
                    first   <= 1'b1;
                end
                SH_LEAD: if (tick) begin
                    phase_hi <= 1'b1;
                    first    <= 1'b0;
                    if (!cpha_l)     rx_sh <= {rx_sh[DATA_W-2:0], in_bit};
                    else if (!first) tx_sh <= tx_sh << 1;
                end
                SH_TRAIL: if (tick) begin
                    phase_hi <= 1'b0;
                    if (cpha_l) rx_sh <= {rx_sh[DATA_W-2:0], in_bit};
                    else        tx_sh <= tx_sh << 1;
                    if (bit_cnt != '0) bit_cnt <= bit_cnt - 1'b1;
                end
                SH_STORE: words_left <= words_left - 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state != SH_IDLE);
        tx_pop  = (state == SH_LOAD) && !tx_empty;
        rx_push = (state == SH_STORE);
        done    = (state == SH_FINISH);
        cs_on   = (state == SH_LOAD) || (state == SH_LEAD) ||
                  (state == SH_TRAIL) || (state == SH_STORE);
        cs_lvl  = busy ? cspol_l : cspol;
        sclk    = (busy ? cpol_l : cpol) ^ phase_hi;
        mosi    = busy ? tx_sh[len_l] : 1'b0;
        in_bit  = loopback ? mosi : miso;
        rx_word = rx_sh;
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_out[i] = (cs_on && idx_l == IDX_W'(i)) ? cs_lvl : ~cs_lvl;
    end

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_CS     = 4,
    parameter int BURST_W    = 7,
    localparam int LEN_W     = $clog2(DATA_W),
    localparam int IDX_W     = $clog2(NUM_CS),
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_o
);

    logic [31:0]       ctrl_q;
    logic [7:0]        ien_q;
    logic              loop_q;
    logic              tc_q;
    logic              ovf_q;
    logic              ctrl_wr, stat_wr, test_wr, flush;
    logic              start_go;
    logic [5:0]        wl_field;
    logic [LEN_W-1:0]  len_m1;
    logic [7:0]        status;

    logic              tx_full, tx_empty, tx_pop;
    logic              rx_full, rx_empty, rx_push;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic              sh_busy, sh_done;

    assign ctrl_wr  = reg_wr && (reg_addr == RIDX_CTRL);
    assign stat_wr  = reg_wr && (reg_addr == RIDX_STAT);
    assign test_wr  = reg_wr && (reg_addr == RIDX_TEST);
    assign flush    = test_wr && reg_wdata[TB_FLUSH];
    assign start_go = ctrl_q[CB_START] && ctrl_q[CB_EN] && ctrl_q[CB_MASTER] && !sh_busy;

    assign wl_field = ctrl_q[CB_LEN_LO +: 6];
    assign len_m1   = (wl_field > 6'(DATA_W - 1)) ? LEN_W'(DATA_W - 1) : wl_field[LEN_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
            loop_q <= 1'b0;
            tc_q   <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (ctrl_wr)       ctrl_q <= reg_wdata;
            else if (start_go) ctrl_q[CB_START] <= 1'b0;
            if (reg_wr && reg_addr == RIDX_IEN) ien_q <= reg_wdata[7:0];
            if (test_wr) loop_q <= reg_wdata[TB_LOOP];
            if (sh_done)                           tc_q <= 1'b1;
            else if (stat_wr && reg_wdata[SB_DONE]) tc_q <= 1'b0;
            if (rx_push && rx_full)                ovf_q <= 1'b1;
            else if (stat_wr && reg_wdata[SB_OVF])  ovf_q <= 1'b0;
        end
    end

    assign status = {tc_q, ovf_q, rx_full, rx_cnt >= CNT_W'(FIFO_DEPTH / 2), !rx_empty,
                     tx_full, tx_cnt >= CNT_W'(FIFO_DEPTH / 2), tx_empty};
    assign irq = |(status & ien_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RIDX_RXD:  reg_rdata = 32'(rx_head);
            RIDX_CTRL: reg_rdata = ctrl_q;
            RIDX_IEN:  reg_rdata[7:0] = ien_q;
            RIDX_STAT: reg_rdata[7:0] = status;
            RIDX_TEST: begin
                reg_rdata[CNT_W-1:0]  = tx_cnt;
                reg_rdata[5 +: CNT_W] = rx_cnt;
                reg_rdata[TB_LOOP]    = loop_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    spi_burst_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (reg_wr && reg_addr == RIDX_TXD),
        .wdata (reg_wdata[DATA_W-1:0]),
        .pop   (tx_pop),
        .rdata (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_burst_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (reg_rd && reg_addr == RIDX_RXD),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_burst_shifter #(.DATA_W(DATA_W), .BURST_W(BURST_W), .NUM_CS(NUM_CS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sck_tick),
        .start    (start_go),
        .cpol     (ctrl_q[CB_CPOL]),
        .cpha     (ctrl_q[CB_CPHA]),
        .cspol    (ctrl_q[CB_CSPOL]),
        .cs_idx   (ctrl_q[CB_IDX_LO +: IDX_W]),
        .len_m1   (len_m1),
        .burst_m1 (ctrl_q[CB_BST_LO +: BURST_W]),
        .loopback (loop_q),
        .tx_empty (tx_empty),
        .tx_word  (tx_head),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .busy     (sh_busy),
        .done     (sh_done),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso),
        .cs_out   (cs_o)
    );

endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker #(
    parameter int DEPTH  = 16,
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              tc_flag,
    input logic              ovf_flag,
    input logic              rx_push,
    input logic              rx_full,
    input logic [NUM_CS-1:0] cs_o,
    input logic              sclk,
    input logic              cpol_cfg,
    input logic              cspol_cfg,
    input logic              start_go,
    input logic              start_bit,
    input logic              ctrl_wr,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt
);

    assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_o == {NUM_CS{~cspol_cfg}});

    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol_cfg);

    assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> tc_flag);

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_go && !ctrl_wr |=> !start_bit);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> busy);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full |=> ovf_flag);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

endmodule

bind spi_burst_engine spi_burst_checker #(
    .DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS), .CNT_W(CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (sh_busy),
    .done      (sh_done),
    .tc_flag   (tc_q),
    .ovf_flag  (ovf_q),
    .rx_push   (rx_push),
    .rx_full   (rx_full),
    .cs_o      (cs_o),
    .sclk      (sclk),
    .cpol_cfg  (ctrl_q[4]),
    .cspol_cfg (ctrl_q[7]),
    .start_go  (start_go),
    .start_bit (ctrl_q[2]),
    .ctrl_wr   (ctrl_wr),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt)
);

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tdiv = 2'd0;
    logic        sck_tick;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_o;

    always #4 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign sck_tick = (tdiv == 2'd3);

    spi_burst_engine dut_i (
        .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 195000) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // ---------------- slave model ----------------
    int          cur_len = 8;
    int          cur_idx = 0;
    logic        cur_cpol = 1'b0, cur_cpha = 1'b0, cur_pol = 1'b0;
    int          lead_cnt = 0, trail_cnt = 0, cap_n = 0;
    logic [31:0] cap_w [16];
    logic [31:0] seed = 32'h0;

    function automatic logic [31:0] msk(input int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
    endfunction

    function automatic logic [31:0] slv_word(input int w);
        return (32'h6D2B_79F5 * 32'(w + 1)) ^ seed;
    endfunction

    function automatic logic [31:0] tx_word(input int i);
        return 32'hC3A5_1F0E ^ (32'h0107_0B0D * 32'(i + 1));
    endfunction

    task automatic update_miso();
        int n;
        int w;
        logic [31:0] sw;
        n  = cur_cpha ? ((lead_cnt > 0) ? lead_cnt - 1 : 0) : trail_cnt;
        w  = n / cur_len;
        sw = slv_word(w);
        miso = sw[cur_len - 1 - (n % cur_len)];
    endtask

    task automatic slave_reset();
        lead_cnt = 0; trail_cnt = 0; cap_n = 0;
        for (int i = 0; i < 16; i++) cap_w[i] = '0;
        update_miso();
    endtask

    task automatic take();
        int w;
        w = cap_n / cur_len;
        if (w < 16) cap_w[w] = {cap_w[w][30:0], mosi};
        cap_n++;
    endtask

    always @(sclk) begin
        if (cs_o[cur_idx] === cur_pol) begin
            if (sclk !== cur_cpol) begin
                lead_cnt++;
                if (!cur_cpha) take();
            end else begin
                trail_cnt++;
                if (cur_cpha) take();
            end
            update_miso();
        end
    end

    // select monitor
    logic mon_en = 1'b0;
    logic prev_act = 1'b0;
    int   cs_bad = 0, cs_drops = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            int act;
            act = 0;
            for (int i = 0; i < 4; i++) if (cs_o[i] === cur_pol) act++;
            if (act > 1 || (act == 1 && cs_o[cur_idx] !== cur_pol)) cs_bad++;
            if (prev_act && act == 0) cs_drops++;
            prev_act = (act != 0);
        end else begin
            prev_act = 1'b0;
        end
    end

    function automatic logic [31:0] mk_ctrl(input int cpol, input int cpha, input int len,
                                            input int n, input int idx, input int pol);
        return 32'h3 | (32'(cpol) << 4) | (32'(cpha) << 5) | (32'(pol) << 7) |
               (32'(idx) << 12) | (32'(len - 1) << 19) | (32'(n - 1) << 25);
    endfunction

    task automatic do_burst(input logic [31:0] ctrl);
        logic [31:0] d;
        wr(3'd2, ctrl | 32'h4);
        for (int k = 0; k < 20000; k++) begin
            rd(3'd4, d);
            if (d[7]) break;
        end
    endtask

    task automatic set_slave(input int cpol, input int cpha, input int len,
                             input int idx, input int pol, input logic [31:0] s);
        cur_cpol = cpol[0]; cur_cpha = cpha[0]; cur_len = len;
        cur_idx = idx; cur_pol = pol[0]; seed = s;
        slave_reset();
    endtask

    task automatic run_burst(input int cpol, input int cpha, input int len, input int n,
                             input int idx, input int pol, input int ntx, input int loop,
                             input logic [31:0] s);
        logic [31:0] ctrl, d, m, e;
        m = msk(len);
        set_slave(cpol, cpha, len, idx, pol, s);
        wr(3'd5, 32'(loop) << 16);
        ctrl = mk_ctrl(cpol, cpha, len, n, idx, pol);
        wr(3'd2, ctrl);
        check("R7 sclk idle level", 32'(sclk), 32'(cpol));
        check("R3 select idle level", 32'(cs_o), {28'd0, {4{~cur_pol}}});
        for (int i = 0; i < ntx; i++) wr(3'd1, tx_word(i));
        cs_bad = 0; cs_drops = 0; mon_en = 1'b1;
        do_burst(ctrl);
        mon_en = 1'b0;
        check("R5 completion flag", 32'(d[7] | 1'b0) & 0 | 32'(reg_rdata[7]), 32'd1);
        check("R2 bit count of burst", 32'(cap_n), 32'(n * len));
        check("R3 only indexed select active", 32'(cs_bad), 32'd0);
        check("R3 one release per burst", 32'(cs_drops), 32'd1);
        for (int i = 0; i < n; i++) begin
            e = (i < ntx) ? (tx_word(i) & m) : 32'd0;
            if (i < ntx) check("R6 mosi word", cap_w[i] & m, e);
            else         check("R10 underrun sends zero", cap_w[i] & m, e);
        end
        rd(3'd5, d);
        check("R4 rx count", 32'(d[9:5]), 32'(n));
        for (int i = 0; i < n; i++) begin
            rd(3'd0, d);
            if (loop != 0) begin
                e = (i < ntx) ? (tx_word(i) & m) : 32'd0;
                check("R8 loopback word", d, e);
            end else begin
                check("R7 miso word by mode", d, slv_word(i) & m);
            end
        end
        wr(3'd4, 32'h80);
        rd(3'd4, d);
        check("R5 completion clear by write one", 32'(d[7]), 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        slave_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R3 reset selects idle", 32'(cs_o), 32'hF);
        check("R7 reset sclk", 32'(sclk), 32'd0);
        check("R5 reset irq", 32'(irq), 32'd0);
        rd(3'd4, d);
        check("R5 reset status", d, 32'h1);
        rd(3'd5, d);
        check("R4 reset counts", d, 32'h0);

        // control readback
        wr(3'd2, 32'hFFFF_FFF3);
        rd(3'd2, d);
        check("R1 control readback", d, 32'hFFFF_FFF3);
        wr(3'd2, 32'h0);
        rd(3'd2, d);
        check("R1 control cleared", d, 32'h0);

        // interrupt from transmit empty
        wr(3'd3, 32'h1);
        @(negedge clk);
        check("R5 irq from enabled empty bit", 32'(irq), 32'd1);
        wr(3'd3, 32'h80);
        @(negedge clk);
        check("R5 irq masked", 32'(irq), 32'd0);

        // sweep of modes, lengths, bursts
        for (int md = 0; md < 4; md++) begin
            for (int li = 0; li < 4; li++) begin
                int len, n, idx, pol;
                len = 8 * (li + 1);
                n   = 1 + ((md * 4 + li) % 5) * 3;
                idx = (md + li) % 4;
                pol = li % 2;
                run_burst(md / 2, md % 2, len, n, idx, pol, n, 0,
                          32'h2545_F491 ^ 32'((md * 4 + li) * 7919));
            end
        end

        // loopback in phase 0 and phase 1
        run_burst(0, 0, 16, 5, 1, 0, 5, 1, 32'h1111_0000);
        run_burst(1, 1, 32, 3, 2, 1, 3, 1, 32'h2222_0000);

        // transmit underrun
        run_burst(0, 1, 8, 6, 0, 0, 2, 0, 32'h3333_0000);

        // irq on completion
        set_slave(0, 0, 8, 0, 0, 32'h4444_0000);
        wr(3'd5, 32'h0);
        do_burst(mk_ctrl(0, 0, 8, 1, 0, 0));
        @(negedge clk);
        check("R5 irq on completion", 32'(irq), 32'd1);
        wr(3'd4, 32'h80);
        @(negedge clk);
        check("R5 irq after clear", 32'(irq), 32'd0);
        rd(3'd0, d);

        // start held while disabled
        wr(3'd2, 32'h6);
        repeat (40) @(negedge clk);
        check("R2 no select while disabled", 32'(cs_o), 32'hF);
        rd(3'd2, d);
        check("R2 start stays pending", 32'(d[2]), 32'd1);
        wr(3'd2, 32'h0);

        // receive overflow
        set_slave(0, 0, 8, 0, 0, 32'h5555_0000);
        do_burst(mk_ctrl(0, 0, 8, 16, 0, 0));
        wr(3'd4, 32'h80);
        set_slave(0, 0, 8, 0, 0, 32'h6666_0000);
        seed = 32'h6666_0000;
        do_burst(mk_ctrl(0, 0, 8, 4, 0, 0));
        rd(3'd4, d);
        check("R11 overflow flag set", 32'(d[6]), 32'd1);
        check("R5 rx full and half bits", 32'(d[5:3]), 32'h7);
        rd(3'd5, d);
        check("R11 rx count held at depth", 32'(d[9:5]), 32'd16);
        seed = 32'h5555_0000;
        for (int i = 0; i < 16; i++) begin
            rd(3'd0, d);
            check("R11 older words kept", d, slv_word(i) & 32'hFF);
        end
        wr(3'd4, 32'h40);
        rd(3'd4, d);
        check("R11 overflow clear by write one", 32'(d[6]), 32'd0);
        wr(3'd4, 32'h80);

        // transmit full, then flush
        for (int i = 0; i < 17; i++) wr(3'd1, tx_word(i));
        rd(3'd5, d);
        check("R4 tx count capped", 32'(d[4:0]), 32'd16);
        rd(3'd4, d);
        check("R5 tx full and half bits", 32'(d[2:0]), 32'h6);
        set_slave(0, 0, 8, 0, 0, 32'h7777_0000);
        do_burst(mk_ctrl(0, 0, 8, 3, 0, 0));
        rd(3'd5, d);
        check("R4 counts after burst", 32'(d[9:0]), (32'd3 << 5) | 32'd13);
        wr(3'd5, 32'h8000_0000);
        rd(3'd5, d);
        check("R9 flush clears counts", 32'(d[9:0]), 32'd0);
        rd(3'd4, d);
        check("R9 status after flush", 32'(d[5:0]), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule